// File: doc/BRIEF.md
# Self-Calibrating Successive-Approximation Section Controller

This block is the digital half of one section in a time-interleaved converter. A sequencer outside the block supplies the current slot of an 18-slot frame, and a single comparator answers one question per clock. The block then runs four activities in that frame: an offset trim loop, a gain trim loop, a sampling slot, and a 13-step binary search. The search drives a trial code into the section's DAC. After the last decision the block publishes the 13-bit code with a one-cycle strobe.

Both trims are slow integrating loops. Each comparator answer in a trim slot moves a signed accumulator by one count. Only the upper bits of the accumulator leave the block as the trim word, so one count is a fraction of a trim step, and a trim step is itself below one output LSB. The loops run in every frame from reset onward. A ready flag rises once enough clocks have passed for the loops to settle.

Slot numbers on `phase_i`, in the order the frame uses them:
- 0: zero-reference sampling.
- 1: offset comparison.
- 2: gain comparison.
- 3: input sampling.
- 4 to 16: bit decisions, where slot 4 decides bit 12 and slot 16 decides bit 0.
- 17: transfer.
- 18 to 31: idle.

Top module: `sar_section_ctrl`

## Requirements
- R1: While `rst_n` is low, `dac_code_o`, `ofs_trim_o`, `gain_trim_o`, `result_o`, `result_valid_o` and `calibrated_o` are all zero.
- R2: In bit slot 4+k (k=0..12), `dac_code_o` shows bits 12..13-k as already decided in this frame, with trial bit 12-k set and all lower bits zero. The bit is kept when `cmp_hi_i` is 1 (input above the DAC) and cleared otherwise. Outside slots 4..16, `dac_code_o` is zero.
- R3: On the clock edge that ends slot 16, the completed code loads into `result_o`. `result_valid_o` is then high for exactly the following cycle. `result_o` holds its value until the next slot-16 edge.
- R4: Each clock in slot 1 moves the offset accumulator by one count: down when `cmp_hi_i` is 1, up when it is 0. `ofs_trim_o` is the accumulator divided by 16 and rounded toward minus infinity, shown as a 6-bit two's-complement value.
- R5: Each clock in slot 2 moves the gain accumulator in the same way as R4, and `gain_trim_o` is derived from it in the same way.
- R6: `cmp_hi_i` has no effect on either trim outside slots 1 and 2. It has no effect on the result in slots 0, 3, 17 and idle.
- R7: Each accumulator saturates at -512 and +511, so the trim words stop at -32 and +31.
- R8: `calibrated_o` rises after exactly 10000 rising clock edges with `rst_n` high, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 5 | Current frame slot from the sequencer |
| cmp_hi_i | input | 1 | Comparator decision, 1 = positive |
| dac_code_o | output | 13 | Trial code for the section DAC |
| ofs_trim_o | output | 6 | Offset trim word, two's complement |
| gain_trim_o | output | 6 | Gain trim word, two's complement |
| result_o | output | 13 | Last completed conversion code |
| result_valid_o | output | 1 | One-cycle strobe in the transfer slot |
| calibrated_o | output | 1 | Trim loops have had time to settle |

## Verification
`dac_code_o` responds in the same cycle as `phase_i`. The bench therefore drives each slot on the falling edge and reads the trial code shortly after, before the rising edge that takes the decision. A trim count lands on the rising edge that ends slot 1 or slot 2, and the result and strobe land on the edge that ends slot 16. The bench reads all of these one falling edge later: trims and result are checked during the transfer slot, and the hold and the strobe's fall are checked in the following frame. The ready flag is sampled on the falling edges just before and just after rising edge 10000 that follows reset release.

// File: rtl/sec_pkg.sv
package sec_pkg;
  // Frame slot numbering shared by the section controller and its sub-blocks.
  localparam int unsigned SLOT_OFS_CMP   = 1;
  localparam int unsigned SLOT_GAIN_CMP  = 2;
  localparam int unsigned SLOT_SAMPLE    = 3;
  localparam int unsigned SLOT_BIT_FIRST = 4;
endpackage

// File: rtl/sec_trim_acc.sv
module sec_trim_acc #(
  parameter int unsigned ACC_W  = 10,
  parameter int unsigned TRIM_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              step_down,
  output logic [TRIM_W-1:0] trim_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic [ACC_W-1:0] acc_q, acc_d;

  // Saturating up/down count, one count per enabled clock.
  always_comb begin
    acc_d = acc_q;
    if (step_down) begin
      if (acc_q != ACC_MIN) acc_d = acc_q - ACC_ONE;
    end else begin
      if (acc_q != ACC_MAX) acc_d = acc_q + ACC_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (step_en) acc_q <= acc_d;
  end

  // Upper bits form the trim word: an arithmetic divide rounding down.
  assign trim_o = acc_q[ACC_W-1 -: TRIM_W];

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_down && acc_q != ACC_MIN) |=> acc_q == $past(acc_q) - ACC_ONE);
  a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_down && acc_q != ACC_MAX) |=> acc_q == $past(acc_q) + ACC_ONE);
  a_r7_floor_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && ((step_down && acc_q == ACC_MIN) || (!step_down && acc_q == ACC_MAX)))
      |=> $stable(acc_q));
  a_r6_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(trim_o));
endmodule

// File: rtl/sec_sar_core.sv
module sec_sar_core
  import sec_pkg::*;
#(
  parameter int unsigned RES_W = 13,
  parameter int unsigned PH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             cmp_hi_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             result_valid_o
);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SLOT_SAMPLE);
  localparam logic [PH_W-1:0] PH_FIRST  = PH_W'(SLOT_BIT_FIRST);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SLOT_BIT_FIRST + RES_W - 1);

  logic             in_search;
  logic [RES_W-1:0] trial_mask;
  logic [RES_W-1:0] work_q, work_d;
  logic             work_en;
  logic [RES_W-1:0] result_q;
  logic             valid_q;
  logic             load_en;

  assign in_search = (phase_i >= PH_FIRST) && (phase_i <= PH_LAST);

  // One trial bit per search slot, MSB in the first slot.
  for (genvar g = 0; g < RES_W; g++) begin : g_trial
    localparam logic [PH_W-1:0] PH_G = PH_W'(SLOT_BIT_FIRST + RES_W - 1 - g);
    assign trial_mask[g] = (phase_i == PH_G);
  end

  assign work_en = in_search || (phase_i == PH_SAMPLE);
  assign load_en = (phase_i == PH_LAST);

  always_comb begin
    work_d = work_q;
    if (phase_i == PH_SAMPLE)     work_d = '0;
    else if (in_search && cmp_hi_i) work_d = work_q | trial_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       work_q <= '0;
    else if (work_en) work_q <= work_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result_q <= '0;
    else if (load_en) result_q <= work_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load_en;
  end

  assign dac_code_o     = in_search ? (work_q | trial_mask) : '0;
  assign result_o       = result_q;
  assign result_valid_o = valid_q;

  a_r2_one_trial: assert property (@(posedge clk) disable iff (!rst_n)
    in_search |-> $countones(dac_code_o & ~work_q) == 1);
  a_r3_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i == PH_LAST) |=> result_valid_o);
  a_r3_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_LAST) |=> !result_valid_o);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_LAST) |=> $stable(result_o));
endmodule

// File: rtl/sec_cal_timer.sv
module sec_cal_timer #(
  parameter int unsigned CAL_CLKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  localparam int unsigned   CNT_W    = $clog2(CAL_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CAL_CLKS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign cnt_en = !done_q;

  always_comb begin
    cnt_d  = cnt_q + CNT_ONE;
    done_d = (cnt_q == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign ready_o = done_q;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);
  a_r8_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && cnt_q != CNT_LAST) |=> !ready_o);
endmodule

// File: rtl/sar_section_ctrl.sv
module sar_section_ctrl
  import sec_pkg::*;
#(
  parameter int unsigned RES_W    = 13,
  parameter int unsigned PH_W     = 5,
  parameter int unsigned ACC_W    = 10,
  parameter int unsigned TRIM_W   = 6,
  parameter int unsigned CAL_CLKS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              cmp_hi_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic [TRIM_W-1:0] ofs_trim_o,
  output logic [TRIM_W-1:0] gain_trim_o,
  output logic [RES_W-1:0]  result_o,
  output logic              result_valid_o,
  output logic              calibrated_o
);
  localparam logic [PH_W-1:0] PH_OFS  = PH_W'(SLOT_OFS_CMP);
  localparam logic [PH_W-1:0] PH_GAIN = PH_W'(SLOT_GAIN_CMP);

  logic ofs_en, gain_en;

  assign ofs_en  = (phase_i == PH_OFS);
  assign gain_en = (phase_i == PH_GAIN);

  sec_trim_acc #(.ACC_W(ACC_W), .TRIM_W(TRIM_W)) u_ofs_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (ofs_en),
    .step_down (cmp_hi_i),
    .trim_o    (ofs_trim_o)
  );

  sec_trim_acc #(.ACC_W(ACC_W), .TRIM_W(TRIM_W)) u_gain_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (gain_en),
    .step_down (cmp_hi_i),
    .trim_o    (gain_trim_o)
  );

  sec_sar_core #(.RES_W(RES_W), .PH_W(PH_W)) u_sar (
    .clk            (clk),
    .rst_n          (rst_n),
    .phase_i        (phase_i),
    .cmp_hi_i       (cmp_hi_i),
    .dac_code_o     (dac_code_o),
    .result_o       (result_o),
    .result_valid_o (result_valid_o)
  );

  sec_cal_timer #(.CAL_CLKS(CAL_CLKS)) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready_o (calibrated_o)
  );
endmodule

// File: tb/sar_section_ctrl_bench.sv
module sar_section_ctrl_bench;
  localparam int RES_W    = 13;
  localparam int PH_W     = 5;
  localparam int TRIM_W   = 6;
  localparam int CAL_CLKS = 10000;
  localparam int ACC_MAX  = 511;
  localparam int ACC_MIN  = -512;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PH_W-1:0]   phase;
  logic              cmp_hi;
  logic [RES_W-1:0]  dac_code;
  logic [TRIM_W-1:0] ofs_trim, gain_trim;
  logic [RES_W-1:0]  result;
  logic              result_valid, calibrated;

  // Comparator model inputs
  logic [RES_W-1:0] vin;
  logic ofs_bit, gain_bit, junk_bit;

  int total = 0;
  int bad = 0;
  int exp_ofs = 0;
  int exp_gain = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sar_section_ctrl u_sar_section_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .phase_i        (phase),
    .cmp_hi_i       (cmp_hi),
    .dac_code_o     (dac_code),
    .ofs_trim_o     (ofs_trim),
    .gain_trim_o    (gain_trim),
    .result_o       (result),
    .result_valid_o (result_valid),
    .calibrated_o   (calibrated)
  );

  // Analog input sits half an LSB above vin, so "input above DAC" is vin >= dac.
  always_comb begin
    if (phase >= 5'd4 && phase <= 5'd16) cmp_hi = (vin >= dac_code);
    else if (phase == 5'd1)              cmp_hi = ofs_bit;
    else if (phase == 5'd2)              cmp_hi = gain_bit;
    else                                 cmp_hi = junk_bit;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_acc(input int acc, input bit down);
    if (down) return (acc > ACC_MIN) ? acc - 1 : acc;
    return (acc < ACC_MAX) ? acc + 1 : acc;
  endfunction

  function automatic int trim_of(input int acc);
    return acc >>> 4;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; phase = 5'd31; vin = '0;
    ofs_bit = 1'b0; gain_bit = 1'b0; junk_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dac", int'(dac_code), 0);
    chk("R1 ofs", int'(ofs_trim), 0);
    chk("R1 gain", int'(gain_trim), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 valid", int'(result_valid), 0);
    chk("R1 calibrated", int'(calibrated), 0);
    rst_n = 1'b1;
    exp_ofs = 0; exp_gain = 0;
  endtask

  // One full frame; the trims and the result are read in the transfer slot.
  task automatic run_frame(input bit with_cal, input bit chk_bits);
    for (int p = 0; p < 18; p++) begin
      @(negedge clk);
      if (!with_cal && (p == 1 || p == 2)) phase = 5'd31;
      else phase = PH_W'(p);
      #1;
      if (chk_bits && p >= 4 && p <= 16) begin
        int b = 16 - p;
        int e = (int'(vin) & ~((1 << (b + 1)) - 1)) | (1 << b);
        chk("R2 trial code", int'(dac_code), e);
      end
    end
    if (with_cal) begin
      exp_ofs  = step_acc(exp_ofs, ofs_bit);
      exp_gain = step_acc(exp_gain, gain_bit);
    end
    chk("R3 valid in transfer", int'(result_valid), 1);
    chk("R2 result", int'(result), int'(vin));
  endtask

  task automatic chk_trims(input string tag);
    chk({tag, " R4 ofs trim"}, int'($signed(ofs_trim)), trim_of(exp_ofs));
    chk({tag, " R5 gain trim"}, int'($signed(gain_trim)), trim_of(exp_gain));
  endtask

  task automatic t_search();
    int codes[7] = '{0, 8191, 4096, 4095, 'h1555, 'h0AAA, 1};
    do_reset();
    foreach (codes[i]) begin
      vin = RES_W'(codes[i]);
      run_frame(1'b1, 1'b1);
    end
    @(negedge clk); phase = 5'd0; #1;
    chk("R2 dac zero outside search", int'(dac_code), 0);
  endtask

  task automatic t_hold();
    logic [RES_W-1:0] first;
    do_reset();
    vin = 13'h0F0F; first = vin;
    run_frame(1'b1, 1'b0);
    vin = 13'h1234;
    for (int p = 0; p < 17; p++) begin
      @(negedge clk); phase = PH_W'(p); #1;
      if (p == 0 || p == 16) begin
        chk("R3 strobe low", int'(result_valid), 0);
        chk("R3 result held", int'(result), int'(first));
      end
    end
    @(negedge clk); phase = 5'd17; #1;
    chk("R3 new result", int'(result), 'h1234);
    chk("R3 strobe", int'(result_valid), 1);
  endtask

  task automatic t_trim_fraction();
    do_reset();
    ofs_bit = 1'b0; gain_bit = 1'b1;
    run_frame(1'b1, 1'b0);
    chk("R4 sub-step up", int'($signed(ofs_trim)), 0);
    chk("R5 sub-step down", int'($signed(gain_trim)), -1);
    for (int f = 0; f < 16; f++) begin
      run_frame(1'b1, 1'b0);
      chk_trims("ramp");
    end
    ofs_bit = 1'b1; gain_bit = 1'b0;
    for (int f = 0; f < 5; f++) begin
      run_frame(1'b1, 1'b0);
      chk_trims("reverse");
    end
  endtask

  task automatic t_saturate();
    do_reset();
    ofs_bit = 1'b1; gain_bit = 1'b0;
    for (int f = 0; f < 600; f++) run_frame(1'b1, 1'b0);
    chk("R7 ofs floor", int'($signed(ofs_trim)), -32);
    chk("R7 gain ceiling", int'($signed(gain_trim)), 31);
    ofs_bit = 1'b0; gain_bit = 1'b1;
    for (int f = 0; f < 20; f++) run_frame(1'b1, 1'b0);
    chk_trims("R7 leave limit");
  endtask

  task automatic t_ignore();
    logic [RES_W-1:0] held;
    do_reset();
    ofs_bit = 1'b1; gain_bit = 1'b0;
    for (int f = 0; f < 20; f++) run_frame(1'b1, 1'b0);
    junk_bit = 1'b1; ofs_bit = 1'b0; gain_bit = 1'b1;
    vin = 13'h0ABC;
    for (int f = 0; f < 3; f++) run_frame(1'b0, 1'b0);
    chk_trims("R6 skip");
    held = result;
    for (int p = 18; p < 32; p++) begin
      @(negedge clk); phase = PH_W'(p); junk_bit = p[0];
    end
    @(negedge clk); #1;
    chk("R6 idle ofs", int'($signed(ofs_trim)), trim_of(exp_ofs));
    chk("R6 idle gain", int'($signed(gain_trim)), trim_of(exp_gain));
    chk("R6 idle result", int'(result), int'(held));
  endtask

  task automatic t_calibrate();
    do_reset();
    repeat (CAL_CLKS - 1) @(negedge clk);
    chk("R8 not yet", int'(calibrated), 0);
    @(negedge clk);
    chk("R8 ready", int'(calibrated), 1);
    repeat (50) @(negedge clk);
    chk("R8 sticky", int'(calibrated), 1);
  endtask

  initial begin
    t_calibrate();
    t_search();
    t_hold();
    t_trim_fraction();
    t_saturate();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule